// File: doc/BRIEF.md
# Three-Port Synchronous Memory with Slice Write Mask

This block is a clocked word memory with three access ports of different kinds. Port A is read-write, port B is write-only and port C is read-only. All ports share one clock. On every rising edge each port samples its own controls into a bank of input flops: an active-low select, an active-low write strobe on port A only, the address, the write data and a per-slice write mask. The array is written, or read, only from those sampled values. The read path has a fixed latency set by a parameter.

A word is `DATA_W` bits wide and is split into `DATA_W/SLICE_W` slices. One mask bit governs each slice, so a write can change some slices of a word and leave the others as they were. When the slice width equals the word width, the mask input is one bit wide and has no effect. Elaboration stops if the word width is not a whole multiple of the slice width.

Read results leave ports A and C as a stream. A result is a data word with a one-cycle valid pulse. There is no ready signal: a memory cannot be stalled, so the consumer must take each word in the cycle its valid is high. Between results the data output holds the last word returned.

Top module: `msram_multi`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first read completes, `a_rdata` and `c_rdata` are zero and `a_rvalid` and `c_rvalid` are low.
- R2: Port A writes only when `a_sel_n` and `a_wr_n` were both low at the capture edge. With `a_sel_n` high, a low `a_wr_n` writes nothing.
- R3: Port B writes whenever `b_sel_n` was low at the capture edge. With `b_sel_n` high, its data and address have no effect.
- R4: Mask bit i set to 1 writes data bits [i*SLICE_W +: SLICE_W]. A slice whose mask bit is 0 keeps its stored value, so an all-zero mask changes nothing.
- R5: A read is captured with `a_sel_n` low and `a_wr_n` high on port A, or with `c_sel_n` low on port C. It returns the word at the captured address on that port's data output, together with a one-cycle valid pulse, exactly `RD_DELAY` rising edges after the capture edge.
- R6: A port's data output changes only in a cycle where its valid is high. A write on port A produces no valid pulse.
- R7: A read captured at the same edge as a write to the same address returns the contents from before that write. A read captured at any later edge returns the written value.
- R8: Writes on ports A and B captured at the same edge to different addresses both take effect. A same-address collision is undefined and must be avoided by the user.
- R9: Reads captured on consecutive edges are pipelined. Each port returns one result per cycle, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_sel_n | input | 1 | Port A select, active low |
| a_wr_n | input | 1 | Port A write strobe, active low |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | DATA_W | Port A write data |
| a_mask | input | DATA_W/SLICE_W | Port A slice write mask, 1 = write |
| a_rdata | output | DATA_W | Port A read data, held between results |
| a_rvalid | output | 1 | Port A read result valid pulse |
| b_sel_n | input | 1 | Port B select, active low (write) |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | DATA_W | Port B write data |
| b_mask | input | DATA_W/SLICE_W | Port B slice write mask, 1 = write |
| c_sel_n | input | 1 | Port C select, active low (read) |
| c_addr | input | ADDR_W | Port C address |
| c_rdata | output | DATA_W | Port C read data, held between results |
| c_rvalid | output | 1 | Port C read result valid pulse |

## Verification
Because all stored state is reached only through reads, a corrupted word or slice shows up on the next read of that address. That read lands `RD_DELAY` edges after its capture as a mismatching word. It may also leave a wrong slice pattern, which points at a mask decode fault. A mis-decoded strobe or select shows up in one of two ways. A stray valid pulse may appear on a write. Or a later read may return data that should not have been written, or that was lost. A wrong pipeline depth moves the valid pulse off its expected cycle and is caught at once. Output drift without a valid pulse is caught on the cycle it happens.

// File: rtl/msram_pkg.sv
package msram_pkg;

  // Kind of access a port supports; picks the decode in the port register.
  typedef enum logic [1:0] {
    PK_RW = 2'd0,
    PK_WO = 2'd1,
    PK_RO = 2'd2
  } port_kind_e;

  // Number of mask slices in a word.
  function automatic int slice_count(input int data_w, input int slice_w);
    return data_w / slice_w;
  endfunction

endpackage

// File: rtl/msram_port_reg.sv
module msram_port_reg
  import msram_pkg::*;
#(
  parameter port_kind_e KIND   = PK_RW,
  parameter int         ADDR_W = 4,
  parameter int         DATA_W = 32,
  parameter int         MASK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [MASK_W-1:0] mask,
  output logic              wr_q,
  output logic              rd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [MASK_W-1:0] mask_q
);

  logic sel_nq;

  // Select and address are sampled on every port kind.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_nq <= 1'b1;
      addr_q <= '0;
    end else begin
      sel_nq <= sel_n;
      addr_q <= addr;
    end
  end

  if (KIND == PK_RO) begin : g_ro
    // Read-only: no write path, data and mask are dropped.
    logic unused_ro_in;
    assign unused_ro_in = ^{wr_n, wdata, mask};
    assign wr_q    = 1'b0;
    assign rd_q    = !sel_nq;
    assign wdata_q = '0;
    assign mask_q  = '0;
  end else begin : g_wr
    // Write-capable ports sample data and mask.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wdata_q <= '0;
      else        wdata_q <= wdata;
    end

    if (MASK_W == 1) begin : g_nomask
      // Slice equals word: every write covers the whole word.
      logic unused_mask_in;
      assign unused_mask_in = ^mask;
      assign mask_q = '1;
    end else begin : g_mask
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask;
      end
    end

    if (KIND == PK_RW) begin : g_rw
      logic wr_nq;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_nq <= 1'b1;
        else        wr_nq <= wr_n;
      end
      assign wr_q = !sel_nq && !wr_nq;
      assign rd_q = !sel_nq &&  wr_nq;
    end else begin : g_wo
      logic unused_wo_in;
      assign unused_wo_in = wr_n;
      assign wr_q = !sel_nq;
      assign rd_q = 1'b0;
    end
  end

endmodule

// File: rtl/msram_array.sv
module msram_array #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int SLICE_W = 8,
  localparam int NSLICE = DATA_W / SLICE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  // write port A
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_waddr,
  input  logic [DATA_W-1:0] a_wd,
  input  logic [NSLICE-1:0] a_msk,
  // write port B
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_waddr,
  input  logic [DATA_W-1:0] b_wd,
  input  logic [NSLICE-1:0] b_msk,
  // read port A
  input  logic              a_re,
  input  logic [ADDR_W-1:0] a_raddr,
  output logic              a_rv,
  output logic [DATA_W-1:0] a_rd,
  // read port C
  input  logic              c_re,
  input  logic [ADDR_W-1:0] c_raddr,
  output logic              c_rv,
  output logic [DATA_W-1:0] c_rd
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Slice-wise writes; port B is applied first so port A wins a collision.
  always_ff @(posedge clk) begin
    for (int s = 0; s < NSLICE; s++) begin
      if (b_we && b_msk[s])
        mem[b_waddr][s*SLICE_W +: SLICE_W] <= b_wd[s*SLICE_W +: SLICE_W];
      if (a_we && a_msk[s])
        mem[a_waddr][s*SLICE_W +: SLICE_W] <= a_wd[s*SLICE_W +: SLICE_W];
    end
  end

  // Read data register: sees contents from before a same-edge write.
  always_ff @(posedge clk) begin
    a_rd <= mem[a_raddr];
    c_rd <= mem[c_raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rv <= 1'b0;
      c_rv <= 1'b0;
    end else begin
      a_rv <= a_re;
      c_rv <= c_re;
    end
  end

endmodule

// File: rtl/msram_rd_pipe.sv
module msram_rd_pipe #(
  parameter int DATA_W   = 32,
  parameter int RD_DELAY = 3,
  localparam int NST     = RD_DELAY - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);

  logic              sv [NST+1];
  logic [DATA_W-1:0] sd [NST+1];

  assign sv[0] = in_vld;
  assign sd[0] = in_data;

  // Extra delay stages between the array register and the output register.
  for (genvar k = 0; k < NST; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sv[k+1] <= 1'b0;
        sd[k+1] <= '0;
      end else begin
        sv[k+1] <= sv[k];
        sd[k+1] <= sd[k];
      end
    end
  end

  // Output register loads only on a result and otherwise holds.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= sv[NST];
      if (sv[NST]) out_data <= sd[NST];
    end
  end

endmodule

// File: rtl/msram_multi.sv
module msram_multi
  import msram_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int SLICE_W  = 8,
  parameter int RD_DELAY = 3,
  localparam int MASK_W  = slice_count(DATA_W, SLICE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_sel_n,
  input  logic              a_wr_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic [MASK_W-1:0] a_mask,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rvalid,
  input  logic              b_sel_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic [MASK_W-1:0] b_mask,
  input  logic              c_sel_n,
  input  logic [ADDR_W-1:0] c_addr,
  output logic [DATA_W-1:0] c_rdata,
  output logic              c_rvalid
);

  if (DATA_W % SLICE_W != 0) begin : g_bad_slice
    $error("DATA_W must be a whole multiple of SLICE_W");
  end
  if (RD_DELAY < 2) begin : g_bad_delay
    $error("RD_DELAY must be at least 2");
  end

  logic              pa_wr, pa_rd, pb_wr, pb_rd, pc_wr, pc_rd;
  logic [ADDR_W-1:0] pa_addr, pb_addr, pc_addr;
  logic [DATA_W-1:0] pa_wd, pb_wd, pc_wd;
  logic [MASK_W-1:0] pa_msk, pb_msk, pc_msk;
  logic              arr_a_rv, arr_c_rv;
  logic [DATA_W-1:0] arr_a_rd, arr_c_rd;
  logic              unused_tie;

  assign unused_tie = ^{pb_rd, pc_wr, pc_wd, pc_msk};

  msram_port_reg #(.KIND(PK_RW), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W)) u_pa (
    .clk(clk), .rst_n(rst_n), .sel_n(a_sel_n), .wr_n(a_wr_n), .addr(a_addr),
    .wdata(a_wdata), .mask(a_mask), .wr_q(pa_wr), .rd_q(pa_rd), .addr_q(pa_addr),
    .wdata_q(pa_wd), .mask_q(pa_msk));

  msram_port_reg #(.KIND(PK_WO), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W)) u_pb (
    .clk(clk), .rst_n(rst_n), .sel_n(b_sel_n), .wr_n(1'b1), .addr(b_addr),
    .wdata(b_wdata), .mask(b_mask), .wr_q(pb_wr), .rd_q(pb_rd), .addr_q(pb_addr),
    .wdata_q(pb_wd), .mask_q(pb_msk));

  msram_port_reg #(.KIND(PK_RO), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .sel_n(c_sel_n), .wr_n(1'b1), .addr(c_addr),
    .wdata('0), .mask('0), .wr_q(pc_wr), .rd_q(pc_rd), .addr_q(pc_addr),
    .wdata_q(pc_wd), .mask_q(pc_msk));

  msram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .a_we(pa_wr), .a_waddr(pa_addr), .a_wd(pa_wd), .a_msk(pa_msk),
    .b_we(pb_wr), .b_waddr(pb_addr), .b_wd(pb_wd), .b_msk(pb_msk),
    .a_re(pa_rd), .a_raddr(pa_addr), .a_rv(arr_a_rv), .a_rd(arr_a_rd),
    .c_re(pc_rd), .c_raddr(pc_addr), .c_rv(arr_c_rv), .c_rd(arr_c_rd));

  msram_rd_pipe #(.DATA_W(DATA_W), .RD_DELAY(RD_DELAY)) u_ra (
    .clk(clk), .rst_n(rst_n), .in_vld(arr_a_rv), .in_data(arr_a_rd),
    .out_vld(a_rvalid), .out_data(a_rdata));

  msram_rd_pipe #(.DATA_W(DATA_W), .RD_DELAY(RD_DELAY)) u_rc (
    .clk(clk), .rst_n(rst_n), .in_vld(arr_c_rv), .in_data(arr_c_rd),
    .out_vld(c_rvalid), .out_data(c_rdata));

endmodule

// File: rtl/msram_multi_chk.sv
module msram_multi_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_sel_n,
  input logic              a_wr_n,
  input logic [ADDR_W-1:0] a_addr,
  input logic              b_sel_n,
  input logic              c_sel_n,
  input logic              pa_wr,
  input logic              pa_rd,
  input logic [ADDR_W-1:0] pa_addr,
  input logic              pb_wr,
  input logic              pc_rd,
  input logic              a_rvalid,
  input logic [DATA_W-1:0] a_rdata,
  input logic              c_rvalid,
  input logic [DATA_W-1:0] c_rdata
);

  // R2
  a_write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pa_wr |-> $past(!a_sel_n && !a_wr_n));

  // R3
  b_write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pb_wr |-> $past(!b_sel_n));

  // R5
  a_read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pa_rd |-> ($past(!a_sel_n && a_wr_n) && pa_addr == $past(a_addr)));

  // R5
  c_read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_rd |-> $past(!c_sel_n));

  // R6
  a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !a_rvalid |-> $stable(a_rdata));

  // R6
  c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !c_rvalid |-> $stable(c_rdata));

endmodule

bind msram_multi msram_multi_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_sel_n(a_sel_n), .a_wr_n(a_wr_n), .a_addr(a_addr),
  .b_sel_n(b_sel_n), .c_sel_n(c_sel_n), .pa_wr(pa_wr), .pa_rd(pa_rd),
  .pa_addr(pa_addr), .pb_wr(pb_wr), .pc_rd(pc_rd), .a_rvalid(a_rvalid),
  .a_rdata(a_rdata), .c_rvalid(c_rvalid), .c_rdata(c_rdata));

// File: tb/msram_multi_test.sv
module msram_multi_test;
  localparam int AW = 4, DW = 32, SW = 8, NS = DW / SW, RDD = 3, DEPTH = 1 << AW;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          a_sel_n = 1'b1, a_wr_n = 1'b1, b_sel_n = 1'b1, c_sel_n = 1'b1;
  logic [AW-1:0] a_addr = '0, b_addr = '0, c_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0, a_rdata, c_rdata;
  logic [NS-1:0] a_mask = '0, b_mask = '0;
  logic          a_rvalid, c_rvalid;

  always #4 clk = ~clk;

  msram_multi #(.ADDR_W(AW), .DATA_W(DW), .SLICE_W(SW), .RD_DELAY(RDD)) uut (
    .clk(clk), .rst_n(rst_n), .a_sel_n(a_sel_n), .a_wr_n(a_wr_n), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_mask(a_mask), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
    .b_sel_n(b_sel_n), .b_addr(b_addr), .b_wdata(b_wdata), .b_mask(b_mask),
    .c_sel_n(c_sel_n), .c_addr(c_addr), .c_rdata(c_rdata), .c_rvalid(c_rvalid));

  int nchk = 0, nfail = 0, cyc = 0;
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] qa_d[$], qc_d[$];
  int            qa_t[$], qc_t[$];
  string         qa_r[$], qc_r[$];
  logic [DW-1:0] last_a = '0, last_c = '0;

  always @(posedge clk) cyc++;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic void mwrite(input int ad, input logic [DW-1:0] d, input logic [NS-1:0] m);
    for (int s = 0; s < NS; s++)
      if (m[s]) model[ad][s*SW +: SW] = d[s*SW +: SW];
  endfunction

  // Driver: ak 0 idle, 1 read, 2 write, 3 write strobe with select high.
  task automatic op(input string tag, input int ak, input int aa, input logic [DW-1:0] ad,
                    input logic [NS-1:0] am, input bit be, input int ba,
                    input logic [DW-1:0] bd, input logic [NS-1:0] bm,
                    input bit ce, input int ca);
    a_sel_n = !(ak == 1 || ak == 2);
    a_wr_n  = !(ak == 2 || ak == 3);
    a_addr = AW'(aa); a_wdata = ad; a_mask = am;
    b_sel_n = !be; b_addr = AW'(ba); b_wdata = bd; b_mask = bm;
    c_sel_n = !ce; c_addr = AW'(ca);
    if (ak == 1) begin qa_d.push_back(model[aa]); qa_t.push_back(cyc + 1 + RDD); qa_r.push_back(tag); end
    if (ce)      begin qc_d.push_back(model[ca]); qc_t.push_back(cyc + 1 + RDD); qc_r.push_back(tag); end
    if (be)      mwrite(ba, bd, bm);
    if (ak == 2) mwrite(aa, ad, am);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op("R6", 0, 0, '0, '0, 0, 0, '0, '0, 0, 0);
  endtask

  // Monitor: scoreboard compare plus hold check (R5, R6, R9).
  always @(negedge clk) begin
    if (rst_n) begin
      if (a_rvalid) begin
        if (qa_d.size() == 0) chk("R6 port A stray valid", 32'd1, 32'd0);
        else begin
          chk({qa_r[0], " port A data"}, a_rdata, qa_d[0]);
          chk("R5 port A latency", 32'(cyc), 32'(qa_t[0]));
          void'(qa_d.pop_front()); void'(qa_t.pop_front()); void'(qa_r.pop_front());
        end
      end else chk("R6 port A hold", a_rdata, last_a);
      if (c_rvalid) begin
        if (qc_d.size() == 0) chk("R6 port C stray valid", 32'd1, 32'd0);
        else begin
          chk({qc_r[0], " port C data"}, c_rdata, qc_d[0]);
          chk("R5 port C latency", 32'(cyc), 32'(qc_t[0]));
          void'(qc_d.pop_front()); void'(qc_t.pop_front()); void'(qc_r.pop_front());
        end
      end else chk("R6 port C hold", c_rdata, last_c);
    end
    last_a = a_rdata;
    last_c = c_rdata;
  end

  always @(posedge clk) begin
    if (cyc > 5000) begin
      nfail++;
      $display("FAIL R5 watchdog: actual cycles %0d expected at most 5000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 a_rdata", a_rdata, '0);
    chk("R1 c_rdata", c_rdata, '0);
    chk("R1 valids", {30'd0, a_rvalid, c_rvalid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valids after release", {30'd0, a_rvalid, c_rvalid}, '0);

    // R2 fill every word through port A with full mask
    for (int i = 0; i < DEPTH; i++)
      op("R2", 2, i, 32'hC3A50000 ^ (i * 32'h01030507), '1, 0, 0, '0, '0, 0, 0);
    // R9 back-to-back reads on A and C
    for (int i = 0; i < DEPTH; i++)
      op("R9", 1, i, '0, '0, 0, 0, '0, '0, 1, DEPTH - 1 - i);
    idle(6);

    // R3 R4 port B partial masks
    op("R4", 0, 0, '0, '0, 1, 3, 32'hDEADBEEF, 4'b0101, 0, 0);
    op("R4", 0, 0, '0, '0, 1, 4, 32'h12345678, 4'b1010, 0, 0);
    op("R4", 0, 0, '0, '0, 1, 5, 32'hFFFFFFFF, 4'b0000, 0, 0);
    op("R3", 0, 0, '0, '0, 1, 12, 32'h0BADF00D, 4'b1111, 0, 0);
    op("R4", 1, 3, '0, '0, 0, 0, '0, '0, 1, 4);
    op("R4", 1, 5, '0, '0, 0, 0, '0, '0, 1, 12);
    // R4 port A single-slice write
    op("R4", 2, 6, 32'hAABBCCDD, 4'b1000, 0, 0, '0, '0, 0, 0);
    op("R4", 1, 6, '0, '0, 0, 0, '0, '0, 0, 0);
    idle(6);

    // R2 strobe without select; R3 port B data without select
    op("R2", 3, 7, 32'hFFFF0000, '1, 0, 13, 32'h55555555, '1, 0, 0);
    op("R2", 1, 7, '0, '0, 0, 0, '0, '0, 1, 13);
    idle(6);

    // R7 same-edge read/write returns old, next edge returns new
    op("R7", 0, 0, '0, '0, 1, 8, 32'h8888AAAA, '1, 1, 8);
    op("R7", 0, 0, '0, '0, 0, 0, '0, '0, 1, 8);
    op("R7", 2, 9, 32'h99990000, '1, 0, 0, '0, '0, 0, 0);
    op("R7", 1, 9, '0, '0, 0, 0, '0, '0, 0, 0);
    idle(6);

    // R8 simultaneous writes to distinct addresses
    op("R8", 2, 10, 32'h10101010, '1, 1, 11, 32'h11111111, '1, 0, 0);
    op("R8", 1, 11, '0, '0, 0, 0, '0, '0, 1, 10);
    // R6 write on port A gives no valid pulse
    op("R6", 2, 14, 32'h14141414, '1, 0, 0, '0, '0, 0, 0);
    idle(10);

    chk("R5 port A queue drained", 32'(qa_d.size()), 32'd0);
    chk("R5 port C queue drained", 32'(qc_d.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule